// File: doc/BRIEF.md
# Instruction Group Former

This block sits between instruction cracking and dispatch. It accepts one decoded instruction record per handshake. Each record carries how many primitive operations the instruction breaks into, a program-order tag, and three flags: branch, writes an architectural register that is not renamed, and must not run speculatively. The block packs these operations into dispatch groups of a fixed number of slots. The last slot is kept for a branch. Unused slots are marked as NOPs, and at most one group leaves per clock.

A group closes for several reasons. A branch closes it. An instruction that writes a register without renaming closes it. A non-speculative instruction always gets a group of its own. A multi-operation instruction that does not fit in the remaining slots closes the current group and opens the next one. A partly filled group is also released in any cycle when no new record is offered. A formed group waits at the output until the downstream resource-available signal is high. While it waits, input ready stays low.

Each group reports the tag of its oldest instruction, so a later exception can roll back to the group boundary. It also reports the tag that owns each slot, so the consumer can tell which slots belong to which instruction.

Top module: `ifg_group_former`

## Requirements
- R1: A group has SLOTS slots. Bit i of `out_ops` is 1 when slot i holds a real operation and 0 when it is a NOP. A NOP slot shows tag 0 in `out_tags`, where slot i occupies bits [i*TAGW +: TAGW]. Groups are emitted one at a time from the output register, so at most one group per clock.
- R2: Slot SLOTS-1 holds only a branch. A branch always goes into that slot as a single operation, whatever its operation count. Any free slots in front of it are emitted as NOPs.
- R3: All operations of one instruction sit in consecutive slots of the same group, starting at the lowest free slot. A non-branch instruction that does not fit in slots 0..SLOTS-2 causes the open group to be emitted alone. The instruction then starts the next group.
- R4: An instruction flagged `in_fixreg` closes its group. The group is emitted in the cycle after the instruction is accepted, with NOPs after its operations.
- R5: An instruction flagged `in_serial` is emitted as a group containing only that instruction. If operations are pending, they go out first as their own group.
- R6: While `out_valid` is 1 and `res_ok` is 0, the output group stays unchanged and `in_ready` is 0.
- R7: `out_first` equals the tag of the oldest instruction in the group.
- R8: If operations are pending, the output is free, and `in_valid` is 0 at a clock edge, the pending group is emitted at that edge.
- R9: An operation count of 0 is taken as 1. A count above SLOTS-1 is taken as SLOTS-1.
- R10: Asserting `rst_n` low discards any partly formed group and clears `out_valid`. After reset, `in_ready` is 1.
- R11: Every accepted instruction appears in exactly one emitted group. None is lost or repeated across stalls or group boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset; takes effect at once, and its release is synchronised inside the block |
| in_valid | input | 1 | an instruction record is offered |
| in_ready | output | 1 | the offered record is taken at this edge |
| in_ops | input | $clog2(SLOTS) | number of primitive operations in the instruction |
| in_branch | input | 1 | instruction is a branch |
| in_fixreg | input | 1 | instruction writes a register that is not renamed |
| in_serial | input | 1 | instruction must not execute speculatively |
| in_tag | input | TAGW | program-order tag of the instruction |
| res_ok | input | 1 | downstream resources for the shown group are available; the group is taken |
| out_valid | output | 1 | a group is presented |
| out_ops | output | SLOTS | per-slot marker: 1 = real operation, 0 = NOP |
| out_tags | output | SLOTS*TAGW | owning tag of each slot |
| out_first | output | TAGW | tag of the oldest instruction in the group |

## Verification
The bench builds the block with the default five slots and a 6-bit tag. With this setting, one instruction can fill all four non-branch slots. A branch can arrive into an empty, partial or full group, and the count clamp is reached by both 0 and 7. These values make every closing rule and the full-then-branch case reachable with short directed sequences. Holding `res_ok` low with a second record waiting checks both the held output and the blocked input.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  // action chosen by the packer for the current cycle
  typedef enum logic [1:0] {
    ACT_NONE,   // nothing changes
    ACT_CLOSE,  // emit the pending group, input not consumed
    ACT_APPEND, // consume input into the pending group
    ACT_SEAL    // consume input and emit the merged group
  } ifg_act_e;
endpackage

// File: rtl/ifg_rst_sync.sv
module ifg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ifg_pack.sv
module ifg_pack
  import ifg_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int TAGW  = 8,
  parameter int CW    = 3
) (
  input  logic [CW-1:0]         acc_cnt,
  input  logic [SLOTS-1:0]      acc_ops,
  input  logic [SLOTS*TAGW-1:0] acc_tags,
  input  logic [TAGW-1:0]       acc_first,
  input  logic                  in_valid,
  input  logic [CW-1:0]         in_ops,
  input  logic                  in_branch,
  input  logic                  in_fixreg,
  input  logic                  in_serial,
  input  logic [TAGW-1:0]       in_tag,
  input  logic                  out_free,
  output logic                  in_ready,
  output ifg_act_e              act,
  output logic                  emit,
  output logic [SLOTS-1:0]      grp_ops,
  output logic [SLOTS*TAGW-1:0] grp_tags,
  output logic [TAGW-1:0]       grp_first,
  output logic [CW-1:0]         nxt_cnt,
  output logic [SLOTS-1:0]      nxt_ops,
  output logic [SLOTS*TAGW-1:0] nxt_tags,
  output logic [TAGW-1:0]       nxt_first
);
  localparam int NB = SLOTS - 1;
  localparam int SW = SLOTS * TAGW;

  logic [CW-1:0]    n_eff;
  logic [CW:0]      sum;
  logic             busy, fits, need_close, seal_in;
  logic [SLOTS-1:0] mrg_ops;
  logic [SW-1:0]    mrg_tags;
  logic [TAGW-1:0]  mrg_first;

  // clamp of the operation count (R9)
  always_comb begin
    if (in_ops == '0)          n_eff = CW'(1);
    else if (int'(in_ops) > NB) n_eff = CW'(NB);
    else                       n_eff = in_ops;
  end

  assign busy       = (acc_cnt != '0);
  assign sum        = {1'b0, acc_cnt} + {1'b0, n_eff};
  assign fits       = (int'(sum) <= NB);
  assign need_close = in_valid && busy && (in_serial || (!in_branch && !fits));
  assign in_ready   = out_free && !need_close;
  assign seal_in    = in_branch || in_fixreg || in_serial;

  // merge of the offered record into the pending group
  always_comb begin
    mrg_ops   = acc_ops;
    mrg_tags  = acc_tags;
    mrg_first = busy ? acc_first : in_tag;
    if (in_branch) begin
      mrg_ops[NB]                = 1'b1;
      mrg_tags[NB*TAGW +: TAGW]  = in_tag;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (i >= int'(acc_cnt) && i < int'(sum)) begin
          mrg_ops[i]               = 1'b1;
          mrg_tags[i*TAGW +: TAGW] = in_tag;
        end
      end
    end
  end

  always_comb begin
    if (!out_free)      act = ACT_NONE;
    else if (need_close) act = ACT_CLOSE;
    else if (in_valid)  act = seal_in ? ACT_SEAL : ACT_APPEND;
    else if (busy)      act = ACT_CLOSE;
    else                act = ACT_NONE;
  end

  always_comb begin
    emit      = (act == ACT_CLOSE) || (act == ACT_SEAL);
    grp_ops   = (act == ACT_CLOSE) ? acc_ops   : mrg_ops;
    grp_tags  = (act == ACT_CLOSE) ? acc_tags  : mrg_tags;
    grp_first = (act == ACT_CLOSE) ? acc_first : mrg_first;
    nxt_cnt   = '0;
    nxt_ops   = '0;
    nxt_tags  = '0;
    nxt_first = '0;
    case (act)
      ACT_NONE: begin
        nxt_cnt   = acc_cnt;
        nxt_ops   = acc_ops;
        nxt_tags  = acc_tags;
        nxt_first = acc_first;
      end
      ACT_APPEND: begin
        nxt_cnt   = sum[CW-1:0];
        nxt_ops   = mrg_ops;
        nxt_tags  = mrg_tags;
        nxt_first = mrg_first;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ifg_acc.sv
module ifg_acc #(
  parameter int SLOTS = 5,
  parameter int TAGW  = 8,
  parameter int CW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [CW-1:0]         nxt_cnt,
  input  logic [SLOTS-1:0]      nxt_ops,
  input  logic [SLOTS*TAGW-1:0] nxt_tags,
  input  logic [TAGW-1:0]       nxt_first,
  output logic [CW-1:0]         cnt_q,
  output logic [SLOTS-1:0]      ops_q,
  output logic [SLOTS*TAGW-1:0] tags_q,
  output logic [TAGW-1:0]       first_q
);
  localparam int NB = SLOTS - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ops_q   <= '0;
      tags_q  <= '0;
      first_q <= '0;
    end else if (en) begin
      cnt_q   <= nxt_cnt;
      ops_q   <= nxt_ops;
      tags_q  <= nxt_tags;
      first_q <= nxt_first;
    end
  end

  // R3
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= NB);

  // R2
  acc_no_last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ops_q[NB] && ((cnt_q == '0) -> (ops_q == '0)));
endmodule

// File: rtl/ifg_hold.sv
module ifg_hold #(
  parameter int SLOTS = 5,
  parameter int TAGW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  emit,
  input  logic [SLOTS-1:0]      grp_ops,
  input  logic [SLOTS*TAGW-1:0] grp_tags,
  input  logic [TAGW-1:0]       grp_first,
  input  logic                  res_ok,
  output logic                  out_free,
  output logic                  out_valid,
  output logic [SLOTS-1:0]      out_ops,
  output logic [SLOTS*TAGW-1:0] out_tags,
  output logic [TAGW-1:0]       out_first
);
  localparam int NB = SLOTS - 1;

  logic en, vld_d;

  assign out_free = !out_valid || res_ok;
  assign en       = emit || (out_valid && res_ok);
  assign vld_d    = emit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (en) out_valid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_ops   <= '0;
      out_tags  <= '0;
      out_first <= '0;
    end else if (emit) begin
      out_ops   <= grp_ops;
      out_tags  <= grp_tags;
      out_first <= grp_first;
    end
  end

  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !res_ok |=> out_valid && $stable(out_ops) && $stable(out_tags)
                            && $stable(out_first));

  // R3
  hold_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ops != '0)
                  && ((out_ops[NB-1:0] & (out_ops[NB-1:0] + 1'b1)) == '0));
endmodule

// File: rtl/ifg_group_former.sv
module ifg_group_former
  import ifg_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int TAGW  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [$clog2(SLOTS)-1:0]   in_ops,
  input  logic                       in_branch,
  input  logic                       in_fixreg,
  input  logic                       in_serial,
  input  logic [TAGW-1:0]            in_tag,
  input  logic                       res_ok,
  output logic                       out_valid,
  output logic [SLOTS-1:0]           out_ops,
  output logic [SLOTS*TAGW-1:0]      out_tags,
  output logic [TAGW-1:0]            out_first
);
  localparam int CW = $clog2(SLOTS);
  localparam int SW = SLOTS * TAGW;

  logic             rst_i_n, out_free, emit, acc_en;
  ifg_act_e         act;
  logic [CW-1:0]    acc_cnt, nxt_cnt;
  logic [SLOTS-1:0] acc_ops, nxt_ops, grp_ops;
  logic [SW-1:0]    acc_tags, nxt_tags, grp_tags;
  logic [TAGW-1:0]  acc_first, nxt_first, grp_first;

  ifg_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  ifg_pack #(.SLOTS(SLOTS), .TAGW(TAGW), .CW(CW)) i_pack (
    .acc_cnt(acc_cnt), .acc_ops(acc_ops), .acc_tags(acc_tags), .acc_first(acc_first),
    .in_valid(in_valid), .in_ops(in_ops), .in_branch(in_branch), .in_fixreg(in_fixreg),
    .in_serial(in_serial), .in_tag(in_tag), .out_free(out_free), .in_ready(in_ready),
    .act(act), .emit(emit), .grp_ops(grp_ops), .grp_tags(grp_tags), .grp_first(grp_first),
    .nxt_cnt(nxt_cnt), .nxt_ops(nxt_ops), .nxt_tags(nxt_tags), .nxt_first(nxt_first)
  );

  assign acc_en = (act != ACT_NONE);

  ifg_acc #(.SLOTS(SLOTS), .TAGW(TAGW), .CW(CW)) i_acc (
    .clk(clk), .rst_n(rst_i_n), .en(acc_en),
    .nxt_cnt(nxt_cnt), .nxt_ops(nxt_ops), .nxt_tags(nxt_tags), .nxt_first(nxt_first),
    .cnt_q(acc_cnt), .ops_q(acc_ops), .tags_q(acc_tags), .first_q(acc_first)
  );

  ifg_hold #(.SLOTS(SLOTS), .TAGW(TAGW)) i_hold (
    .clk(clk), .rst_n(rst_i_n), .emit(emit), .grp_ops(grp_ops), .grp_tags(grp_tags),
    .grp_first(grp_first), .res_ok(res_ok), .out_free(out_free), .out_valid(out_valid),
    .out_ops(out_ops), .out_tags(out_tags), .out_first(out_first)
  );

  // R6
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid && !res_ok |-> !in_ready);

  // R4
  closing_emits_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_valid && in_ready && (in_fixreg || in_branch || in_serial) |=> out_valid);

  // R5
  serial_alone_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_valid && in_ready && in_serial |=> out_valid && out_first == $past(in_tag));
endmodule

// File: tb/test_ifg_group_former.sv
module test_ifg_group_former;
  localparam int SLOTS = 5;
  localparam int TAGW  = 6;
  localparam int SW    = SLOTS * TAGW;

  logic             clk = 1'b0;
  logic             rst_n, in_valid, in_ready, in_branch, in_fixreg, in_serial, res_ok;
  logic [2:0]       in_ops;
  logic [TAGW-1:0]  in_tag, out_first;
  logic             out_valid;
  logic [SLOTS-1:0] out_ops;
  logic [SW-1:0]    out_tags;

  int total = 0;
  int bad   = 0;
  int ncap  = 0;
  int base  = 0;
  logic [SLOTS-1:0] cap_ops   [64];
  logic [SW-1:0]    cap_tags  [64];
  logic [TAGW-1:0]  cap_first [64];

  always #4 clk = ~clk;

  ifg_group_former #(.SLOTS(SLOTS), .TAGW(TAGW)) i_ifg_group_former (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_ops(in_ops),
    .in_branch(in_branch), .in_fixreg(in_fixreg), .in_serial(in_serial), .in_tag(in_tag),
    .res_ok(res_ok), .out_valid(out_valid), .out_ops(out_ops), .out_tags(out_tags),
    .out_first(out_first)
  );

  // capture every group taken by the consumer
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && res_ok && ncap < 64) begin
      cap_ops[ncap]   = out_ops;
      cap_tags[ncap]  = out_tags;
      cap_first[ncap] = out_first;
      ncap++;
    end
  end

  function automatic logic [SW-1:0] pk(int t0, int t1, int t2, int t3, int t4);
    return {TAGW'(t4), TAGW'(t3), TAGW'(t2), TAGW'(t1), TAGW'(t0)};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_grp(int k, logic [SLOTS-1:0] eops, logic [SW-1:0] etags,
                         int efirst, string req);
    int idx = base + k;
    if (idx >= ncap) begin
      check(1'b0, req, "group missing", 64'(ncap - base), 64'(k + 1));
    end else begin
      check(cap_ops[idx] == eops, req, "slot ops", 64'(cap_ops[idx]), 64'(eops));
      check(cap_tags[idx] == etags, req, "slot tags", 64'(cap_tags[idx]), 64'(etags));
      check(cap_first[idx] == TAGW'(efirst), req, "oldest tag",
            64'(cap_first[idx]), 64'(efirst));
    end
  endtask

  task automatic chk_cnt(int n, string req);
    check((ncap - base) == n, req, "group count", 64'(ncap - base), 64'(n));
  endtask

  // present one record starting at a falling edge, return at the falling edge after it is taken
  task automatic put(int n, bit br, bit fx, bit se, int tag);
    in_valid  = 1'b1;
    in_ops    = 3'(n);
    in_branch = br;
    in_fixreg = fx;
    in_serial = se;
    in_tag    = TAGW'(tag);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
  endtask

  task automatic drop();
    in_valid  = 1'b0;
    in_branch = 1'b0;
    in_fixreg = 1'b0;
    in_serial = 1'b0;
    in_ops    = '0;
    in_tag    = '0;
  endtask

  task automatic settle();
    drop();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drop();
    res_ok = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_branch_third();
    base = ncap;
    put(1, 0, 0, 0, 1);
    put(1, 0, 0, 0, 2);
    put(1, 1, 0, 0, 3);
    settle();
    chk_cnt(1, "R2");
    chk_grp(0, 5'b10011, pk(1, 2, 0, 0, 3), 1, "R2 R7");
  endtask

  task automatic t_crack_split();
    base = ncap;
    put(3, 0, 0, 0, 4);
    put(2, 0, 0, 0, 5);
    settle();
    chk_cnt(2, "R3 R11");
    chk_grp(0, 5'b00111, pk(4, 4, 4, 0, 0), 4, "R3");
    chk_grp(1, 5'b00011, pk(5, 5, 0, 0, 0), 5, "R8");
  endtask

  task automatic t_fixreg();
    base = ncap;
    put(1, 0, 0, 0, 6);
    put(2, 0, 1, 0, 7);
    put(1, 0, 0, 0, 8);
    settle();
    chk_cnt(2, "R4 R11");
    chk_grp(0, 5'b00111, pk(6, 7, 7, 0, 0), 6, "R4");
    chk_grp(1, 5'b00001, pk(8, 0, 0, 0, 0), 8, "R4");
  endtask

  task automatic t_serial();
    base = ncap;
    put(1, 0, 0, 0, 9);
    put(2, 0, 0, 1, 10);
    put(1, 0, 0, 0, 11);
    settle();
    chk_cnt(3, "R5 R11");
    chk_grp(0, 5'b00001, pk(9, 0, 0, 0, 0), 9, "R5");
    chk_grp(1, 5'b00011, pk(10, 10, 0, 0, 0), 10, "R5");
    chk_grp(2, 5'b00001, pk(11, 0, 0, 0, 0), 11, "R5");
  endtask

  task automatic t_full_branch();
    base = ncap;
    put(4, 0, 0, 0, 12);
    put(1, 1, 0, 0, 13);
    put(2, 0, 0, 0, 14);
    put(2, 0, 0, 0, 15);
    put(1, 0, 0, 0, 16);
    settle();
    chk_cnt(3, "R3 R11");
    chk_grp(0, 5'b11111, pk(12, 12, 12, 12, 13), 12, "R2");
    chk_grp(1, 5'b01111, pk(14, 14, 15, 15, 0), 14, "R3");
    chk_grp(2, 5'b00001, pk(16, 0, 0, 0, 0), 16, "R8");
  endtask

  task automatic t_lone_branch();
    base = ncap;
    put(3, 1, 0, 0, 21);
    settle();
    chk_cnt(1, "R2");
    chk_grp(0, 5'b10000, pk(0, 0, 0, 0, 21), 21, "R2");
  endtask

  task automatic t_clamp();
    base = ncap;
    put(0, 0, 0, 0, 17);
    put(7, 0, 0, 0, 18);
    settle();
    chk_cnt(2, "R9");
    chk_grp(0, 5'b00001, pk(17, 0, 0, 0, 0), 17, "R9");
    chk_grp(1, 5'b01111, pk(18, 18, 18, 18, 0), 18, "R9");
  endtask

  task automatic t_stall();
    logic [SW-1:0] held;
    base = ncap;
    res_ok = 1'b0;
    put(1, 0, 1, 0, 19);
    in_valid  = 1'b1;
    in_ops    = 3'd1;
    in_fixreg = 1'b1;
    in_tag    = TAGW'(20);
    #1;
    held = out_tags;
    for (int k = 0; k < 4; k++) begin
      check(in_ready == 1'b0, "R6", "in_ready during stall", 64'(in_ready), 64'd0);
      check(out_valid && out_tags == held && out_first == TAGW'(19), "R6",
            "held group", 64'(out_tags), 64'(held));
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    res_ok = 1'b1;
    @(negedge clk);
    settle();
    chk_cnt(2, "R6 R11");
    chk_grp(0, 5'b00001, pk(19, 0, 0, 0, 0), 19, "R6");
    chk_grp(1, 5'b00001, pk(20, 0, 0, 0, 0), 20, "R6");
  endtask

  task automatic t_reset_mid();
    base = ncap;
    in_valid = 1'b1;
    in_ops   = 3'd2;
    in_tag   = TAGW'(30);
    @(negedge clk);
    drop();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10", "out_valid after mid reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R10", "in_ready after mid reset", 64'(in_ready), 64'd1);
    chk_cnt(0, "R10");
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_branch_third();
    t_crack_split();
    t_fixreg();
    t_serial();
    t_full_branch();
    t_lone_branch();
    t_clamp();
    t_stall();
    t_reset_mid();
    check(out_valid == 1'b0, "R1", "idle output", 64'(out_valid), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule